// File: doc/BRIEF.md
# Audio DMA Channel Status and Interrupt Hub

This block keeps the status and control registers of three audio DMA channels (capture, playback and microphone) and the global control and status registers that sit beside them. Software reaches every register through one write port and one combinational read port. The per-channel engines that fetch descriptors and move samples sit outside this block. Those engines report events on single-cycle pulse inputs, and each pulse sets the matching status flag.

Each channel raises an interrupt when an enabled completion flag is set. The three channel interrupts are visible live in global status, and one registered level-sensitive output is the OR of them. Status registers combine bits that software clears by writing one with bits that only the engine can change. A channel register reset, started from the control register, puts the channel back into the halted state and keeps its interrupt enables.

Top module: `audio_dma_irq_hub`

## Requirements
- R1: After reset every channel status reads 0x01, every channel control reads 0x00, global control reads 0x00, global status reads 0x00100 and `irq` is low.
- R2: The register map is: channel c (0 = capture, 1 = playback, 2 = microphone) has status at address {c,2'b00} and control at {c,2'b01}; global status is at 0xC and global control at 0xD; addresses with no register read zero.
- R3: Channel status holds FIFO error at bit 4, buffer done at bit 3 and last-buffer done at bit 2, and writing 1 to any of these clears it while writing 0 leaves it. Halted (bit 0) and current-is-last (bit 1) do not change on any software status write.
- R4: A channel interrupt is (bit 2 of status AND control bit 2) OR (bit 3 of status AND control bit 4). A FIFO error never raises an interrupt, even with control bit 3 set.
- R5: `irq` is registered. It changes on the clock edge after the edge that changed the status or control bits it depends on, and it drops once no channel has an enabled cause.
- R6: Global status bits 5, 6 and 7 read as the live interrupt of the capture, playback and microphone channels.
- R7: A global control write that has bit 2 or bit 1 set is dropped. Any other such write stores bits 5:0.
- R8: Global status bits 15, 11, 10 and 0 are set by `codec_evt[3]`, `[2]`, `[1]` and `[0]` and cleared by writing 1. Bits 17:16 are set by writing 1, and writing 0 leaves them. Software writes change no other bit, and bit 8 always reads 1.
- R9: A channel control write with bit 1 set makes control equal to its previous value AND 0x1C and sets status to 0x01.
- R10: An event pulse that sets a flag in the same cycle as a software clear of that flag leaves the flag set.
- R11: `evt_halt` sets status bit 0 and `evt_last` sets bit 1, while `evt_run` clears both. A set pulse wins over `evt_run`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Combinational read data |
| evt_fifo_err | input | 3 | Per-channel FIFO error pulse |
| evt_buf_done | input | 3 | Per-channel buffer completion pulse |
| evt_lvb_done | input | 3 | Per-channel last-buffer completion pulse |
| evt_last | input | 3 | Per-channel current-is-last pulse |
| evt_halt | input | 3 | Per-channel halted pulse |
| evt_run | input | 3 | Per-channel resume pulse, clears halted and current-is-last |
| codec_evt | input | 4 | Global status event pulses |
| irq | output | 1 | Level-sensitive interrupt |

## Verification
The hardest case to reach is a collision: an engine pulse that sets a flag lands in the same cycle as the software write that clears that flag. The bench drives the write and the pulse in one shared task, so both land on one clock edge, and it does this for a channel flag and for a global status flag. Timing of `irq` is another such case. It is sampled one edge after the clearing write, where it must still be high, and again one edge later, where it must be low. With two channels interrupting at once, the bench clears one of them and checks that the line stays high.

// File: rtl/audio_dma_irq_hub.sv
module audio_dma_irq_hub #(
  parameter int NCH = 3,
  parameter int AW  = 4,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [NCH-1:0] evt_fifo_err,
  input  logic [NCH-1:0] evt_buf_done,
  input  logic [NCH-1:0] evt_lvb_done,
  input  logic [NCH-1:0] evt_last,
  input  logic [NCH-1:0] evt_halt,
  input  logic [NCH-1:0] evt_run,
  input  logic [3:0]    codec_evt,
  output logic          irq
);
  localparam int SW = 5;
  localparam logic [SW-1:0] CLR_MASK = 5'b11100;
  localparam logic [SW-1:0] KEEP_EN  = 5'b11100;
  localparam logic [AW-1:0] A_GSTA = 4'hC;
  localparam logic [AW-1:0] A_GCTL = 4'hD;

  logic [NCH*SW-1:0] sr_flat;
  logic [NCH*SW-1:0] cr_flat;
  logic [NCH-1:0]    ch_int;
  logic [5:0]        gctl;
  logic [3:0]        gs_clr;
  logic [1:0]        gs_rw;
  logic [17:0]       gsta_rd;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SW-1:0] sr, cr, sr_sw, sr_set;
    wire sel    = wr_en && (wr_addr[3:2] == 2'(c));
    wire st_wr  = sel && (wr_addr[1:0] == 2'd0);
    wire ct_wr  = sel && (wr_addr[1:0] == 2'd1);
    wire rst_rq = ct_wr && wr_data[1];

    assign sr_set = {evt_fifo_err[c], evt_buf_done[c], evt_lvb_done[c], evt_last[c], evt_halt[c]};

    always_comb begin
      sr_sw = sr;
      if (rst_rq) sr_sw = 5'h01;
      else begin
        if (st_wr) sr_sw = sr_sw & ~(wr_data[SW-1:0] & CLR_MASK);
        if (evt_run[c]) sr_sw[1:0] = 2'b00;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sr <= 5'h01;
        cr <= '0;
      end else begin
        sr <= sr_sw | sr_set;
        if (rst_rq) cr <= cr & KEEP_EN;
        else if (ct_wr) cr <= wr_data[SW-1:0];
      end
    end

    assign ch_int[c] = (sr[2] & cr[2]) | (sr[3] & cr[4]);
    assign sr_flat[c*SW +: SW] = sr;
    assign cr_flat[c*SW +: SW] = cr;
  end

  wire gs_wr = wr_en && (wr_addr == A_GSTA);
  wire gc_wr = wr_en && (wr_addr == A_GCTL) && !(wr_data[2] | wr_data[1]);
  wire [3:0] gs_wclr = gs_wr ? {wr_data[15], wr_data[11], wr_data[10], wr_data[0]} : 4'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gctl   <= '0;
      gs_clr <= '0;
      gs_rw  <= '0;
      irq    <= 1'b0;
    end else begin
      if (gc_wr) gctl <= wr_data[5:0];
      gs_clr <= (gs_clr & ~gs_wclr) | codec_evt;
      if (gs_wr) gs_rw <= gs_rw | wr_data[17:16];
      irq <= |ch_int;
    end
  end

  assign gsta_rd = {gs_rw, gs_clr[3], 3'b000, gs_clr[2], gs_clr[1], 1'b0, 1'b1,
                    ch_int[2], ch_int[1], ch_int[0], 4'b0000, gs_clr[0]};

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_GSTA) rd_data = DW'(gsta_rd);
    else if (rd_addr == A_GCTL) rd_data = DW'(gctl);
    else if (32'(rd_addr[3:2]) < NCH) begin
      case (rd_addr[1:0])
        2'd0: rd_data = DW'(sr_flat[rd_addr[3:2]*SW +: SW]);
        2'd1: rd_data = DW'(cr_flat[rd_addr[3:2]*SW +: SW]);
        default: rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/audio_dma_irq_hub_chk.sv
module audio_dma_irq_hub_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic [2:0]  evt_fifo_err,
  input logic [2:0]  evt_buf_done,
  input logic [2:0]  evt_lvb_done,
  input logic [2:0]  evt_last,
  input logic [2:0]  evt_halt,
  input logic [2:0]  evt_run,
  input logic [14:0] sr_flat,
  input logic [14:0] cr_flat,
  input logic [5:0]  gctl,
  input logic        irq
);
  logic [2:0] cause;
  for (genvar c = 0; c < 3; c++) begin : g_c
    assign cause[c] = (sr_flat[c*5+2] && cr_flat[c*5+2]) || (sr_flat[c*5+3] && cr_flat[c*5+4]);

    wire st_hit = wr_en && wr_addr == {2'(c), 2'd0};
    wire rs_hit = wr_en && wr_addr == {2'(c), 2'd1} && wr_data[1];
    wire quiet  = !(evt_fifo_err[c] | evt_buf_done[c] | evt_lvb_done[c] | evt_last[c] | evt_halt[c]);

    a_r9_ctl_reset: assert property (@(posedge clk) disable iff (!rst_n)
      rs_hit && quiet |=> sr_flat[c*5 +: 5] == 5'h01 && cr_flat[c*5 +: 2] == 2'b00);

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt_buf_done[c] |=> sr_flat[c*5+3]);

    a_r3_ro_hold: assert property (@(posedge clk) disable iff (!rst_n)
      st_hit && !evt_halt[c] && !evt_last[c] && !evt_run[c] |=> sr_flat[c*5 +: 2] == $past(sr_flat[c*5 +: 2]));
  end

  a_r5_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|cause));

  a_r7_gctl_drop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 4'hD && (wr_data[2] || wr_data[1]) |=> $stable(gctl));
endmodule

bind audio_dma_irq_hub audio_dma_irq_hub_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .evt_fifo_err(evt_fifo_err), .evt_buf_done(evt_buf_done), .evt_lvb_done(evt_lvb_done),
  .evt_last(evt_last), .evt_halt(evt_halt), .evt_run(evt_run),
  .sr_flat(sr_flat), .cr_flat(cr_flat), .gctl(gctl), .irq(irq)
);

// File: tb/audio_dma_irq_hub_test.sv
module audio_dma_irq_hub_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [2:0] e_f = 0, e_b = 0, e_l = 0, e_c = 0, e_h = 0, e_r = 0;
  logic [3:0] codec_evt = 0;
  logic irq;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  audio_dma_irq_hub uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_fifo_err(e_f), .evt_buf_done(e_b), .evt_lvb_done(e_l),
    .evt_last(e_c), .evt_halt(e_h), .evt_run(e_r),
    .codec_evt(codec_evt), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [3:0] a, input logic [31:0] d,
                     input logic [2:0] f, input logic [2:0] b, input logic [2:0] l,
                     input logic [2:0] c, input logic [2:0] h, input logic [2:0] r,
                     input logic [3:0] g);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    e_f = f; e_b = b; e_l = l; e_c = c; e_h = h; e_r = r; codec_evt = g;
    @(negedge clk);
    wr_en = 0; e_f = 0; e_b = 0; e_l = 0; e_c = 0; e_h = 0; e_r = 0; codec_evt = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc(1, a, d, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset;
    for (int c = 0; c < 3; c++) begin
      rd_chk("R1 status", {2'(c), 2'd0}, 32'h01);
      rd_chk("R1 control", {2'(c), 2'd1}, 32'h00);
    end
    rd_chk("R1 gsta", 4'hC, 32'h100);
    rd_chk("R1 gctl", 4'hD, 32'h0);
    rd_chk("R2 unused", 4'hE, 32'h0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_w1c;
    cyc(0, 0, 0, 3'b010, 3'b010, 3'b010, 0, 0, 0, 0);
    rd_chk("R3 flags set", 4'h4, 32'h1D);
    wr(4'h4, 32'h08);
    rd_chk("R3 clear buf", 4'h4, 32'h15);
    wr(4'h4, 32'h14);
    rd_chk("R3 clear rest", 4'h4, 32'h01);
  endtask

  task automatic t_ro;
    cyc(0, 0, 0, 0, 0, 0, 3'b100, 0, 0, 0);
    rd_chk("R11 last set", 4'h8, 32'h03);
    wr(4'h8, 32'h03);
    rd_chk("R3 ro write 1", 4'h8, 32'h03);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 3'b100, 0);
    rd_chk("R11 run clears", 4'h8, 32'h00);
    wr(4'h8, 32'h1F);
    rd_chk("R3 ro stays 0", 4'h8, 32'h00);
    cyc(0, 0, 0, 0, 0, 0, 0, 3'b100, 3'b100, 0);
    rd_chk("R11 halt wins over run", 4'h8, 32'h01);
  endtask

  task automatic t_irq;
    wr(4'h1, 32'h08);
    cyc(0, 0, 0, 3'b001, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R4 fifo no irq", irq, 0);
    rd_chk("R4 gsta no ch int", 4'hC, 32'h100);
    wr(4'h0, 32'h10);
    wr(4'h1, 32'h04);
    cyc(0, 0, 0, 0, 0, 3'b001, 0, 0, 0, 0);
    chk("R5 irq latency", irq, 0);
    @(negedge clk);
    chk("R4 lvb irq", irq, 1);
    rd_chk("R6 gsta bit5", 4'hC, 32'h120);
    wr(4'h0, 32'h04);
    chk("R5 irq held one edge", irq, 1);
    @(negedge clk);
    chk("R5 irq drops", irq, 0);
    wr(4'h5, 32'h10);
    wr(4'h9, 32'h10);
    cyc(0, 0, 0, 0, 3'b110, 0, 0, 0, 0, 0);
    @(negedge clk);
    rd_chk("R6 gsta bits 6,7", 4'hC, 32'h1C0);
    wr(4'h4, 32'h08);
    @(negedge clk);
    chk("R5 irq one left", irq, 1);
    rd_chk("R6 gsta bit7", 4'hC, 32'h180);
    wr(4'h8, 32'h08);
    @(negedge clk);
    chk("R5 irq all clear", irq, 0);
  endtask

  task automatic t_gctl;
    wr(4'hD, 32'h3F);
    rd_chk("R7 drop both", 4'hD, 32'h00);
    wr(4'hD, 32'hF9);
    rd_chk("R7 store", 4'hD, 32'h39);
    wr(4'hD, 32'h04);
    rd_chk("R7 drop bit2", 4'hD, 32'h39);
    wr(4'hD, 32'h02);
    rd_chk("R7 drop bit1", 4'hD, 32'h39);
    wr(4'hD, 32'h00);
    rd_chk("R7 store zero", 4'hD, 32'h00);
  endtask

  task automatic t_gsta;
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 4'hF);
    rd_chk("R8 events", 4'hC, 32'h8D01);
    wr(4'hC, 32'h0401);
    rd_chk("R8 w1c", 4'hC, 32'h8900);
    wr(4'hC, 32'h0003_77FE);
    rd_chk("R8 rw set, ro ignored", 4'hC, 32'h3_8900);
    wr(4'hC, 32'h0);
    rd_chk("R8 zero write", 4'hC, 32'h3_8900);
    wr(4'hC, 32'h8800);
    rd_chk("R8 clear rest", 4'hC, 32'h3_0100);
  endtask

  task automatic t_ctl_reset;
    wr(4'h5, 32'h1D);
    rd_chk("R9 ctl before", 4'h5, 32'h1D);
    cyc(0, 0, 0, 3'b010, 3'b010, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R9 irq before", irq, 1);
    wr(4'h5, 32'h02);
    rd_chk("R9 ctl keeps enables", 4'h5, 32'h1C);
    rd_chk("R9 status halted", 4'h4, 32'h01);
    @(negedge clk);
    chk("R9 irq gone", irq, 0);
  endtask

  task automatic t_collide;
    cyc(0, 0, 0, 0, 3'b001, 0, 0, 0, 0, 0);
    rd_chk("R10 setup", 4'h0, 32'h09);
    cyc(1, 4'h0, 32'h08, 0, 3'b001, 0, 0, 0, 0, 0);
    rd_chk("R10 set wins", 4'h0, 32'h09);
    wr(4'h0, 32'h08);
    rd_chk("R10 later clear", 4'h0, 32'h01);
    cyc(1, 4'hC, 32'h1, 0, 0, 0, 0, 0, 0, 4'h1);
    rd_chk("R10 gsta set wins", 4'hC, 32'h3_0101);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_w1c;
    t_ro;
    t_irq;
    t_gctl;
    t_gsta;
    t_ctl_reset;
    t_collide;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule